// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block is one DMA channel. It takes a transfer that has been set up on its configuration inputs and turns it into cycles on a simple internal bus master port. A one-cycle `start` pulse latches the configuration and checks it. After that the channel waits for `dreq`, raises `bus_req` and issues one bus cycle per clock in which `bus_gnt` is high. It stops with `done` when the programmed count of units has moved. A configuration that is not permitted sets `err` instead, and no bus cycle is issued.

There are three address modes:
- **Single-address.** One bus cycle per unit. `bus_dack` strobes the external device while the address selects the other endpoint.
- **Dual-address direct.** A read from the source address is followed by a write to the destination address.
- **Dual-address indirect.** The source address points at a word. That word is read first and holds the real operand address. The operand is then read and written to the destination.

There are two ways of holding the bus:
- **Cycle-steal.** The bus is handed back after every unit.
- **Burst.** The bus is kept until the count is exhausted.

Top module: `dma_chan_seq`

## Requirements
- R1: Endpoint codes are 0 = acknowledge-strobed device, 1 = external memory, 2 = memory-mapped external device, 3 = on-chip memory, 4 = on-chip peripheral. A start is legal only when all of the following hold:
  - the count is non-zero;
  - both codes are 4 or below;
  - in single-address mode, indirect is off, the endpoint selected by `cfg_dack_is_src` has code 0, and the other endpoint has code 1 or 2;
  - in dual-address mode, neither endpoint has code 0.
  An illegal start sets `err` one cycle later and leaves `done` low, and no bus cycle follows.
- R2: In single-address mode each unit is exactly one bus cycle with `bus_dack` high.
  - With `cfg_dack_is_src`=1 the cycle is a write to the destination address.
  - Otherwise it is a read from the source address.
- R3: In dual direct mode each unit is a read at the source address followed by a write at the destination address. The write carries the data that was read.
- R4: In dual indirect mode each unit is three cycles:
  - a read at the source (pointer) address;
  - a read at the address returned by that first read;
  - a write of the second read's data to the destination.
- R5: After each unit the source address (in indirect mode, the pointer) advances by DW/8 when `cfg_src_inc` is set. The destination address advances by DW/8 when `cfg_dst_inc` is set. An address whose increment bit is clear stays fixed.
- R6: In cycle-steal mode `bus_req` falls after every unit. The next unit begins only after `dreq` is seen high and the bus is granted again.
- R7: In burst mode `dreq` is sampled only before the first unit. `bus_req` stays high until the last unit completes.
- R8: The cycle after the last unit, `done` is high and `bus_req` is low. `done` stays high until the next start.
- R9: A `start` pulse, and any change on the configuration inputs, while a transfer is in progress has no effect on that transfer.
- R10: Under reset `bus_req`, `bus_rd`, `bus_wr`, `bus_dack`, `done` and `err` are low.
- R11: A bus strobe is issued only in a cycle where both `bus_req` and `bus_gnt` are high. A cycle without grant stalls the sequence without losing its position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | One-cycle pulse that latches and checks the configuration |
| cfg_src | input | AW | Source address, or pointer address in indirect mode |
| cfg_dst | input | AW | Destination address |
| cfg_cnt | input | CW | Number of units to move |
| cfg_single | input | 1 | 1 = single-address mode, 0 = dual-address mode |
| cfg_indirect | input | 1 | Dual mode: source is a pointer to the operand address |
| cfg_burst | input | 1 | 1 = burst, 0 = cycle-steal |
| cfg_dack_is_src | input | 1 | Single mode: acknowledge-strobed device is the source |
| cfg_src_inc | input | 1 | Increment source/pointer after each unit |
| cfg_dst_inc | input | 1 | Increment destination after each unit |
| cfg_src_type | input | 3 | Source endpoint code (see R1) |
| cfg_dst_type | input | 3 | Destination endpoint code (see R1) |
| dreq | input | 1 | Transfer request |
| bus_gnt | input | 1 | Bus grant |
| bus_rdata | input | DW | Read data, valid in the cycle of a read strobe |
| bus_req | output | 1 | Bus request |
| bus_addr | output | AW | Bus address |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_dack | output | 1 | Acknowledge strobe to the external device |
| bus_wdata | output | DW | Write data |
| done | output | 1 | Transfer complete |
| err | output | 1 | Last start was rejected |

## Verification
The end of a unit can coincide with several other events in the same clock edge:
- the count reaching its last value;
- a grant drop in the following cycle;
- a `start` pulse or a configuration change while busy.

Grant is randomly withheld while requests are pending, so stalls land on every phase, including the final write. The bench then judges each transfer by several measures:
- the logged sequence of strobes, addresses and write data, compared against a trace built from the requirements;
- the number of `bus_req` rising edges;
- `done` and `err` once the transfer has finished.

One directed case pulses `start` with a different configuration in the middle of a cycle-steal transfer. The logged trace must still be the original one.

// File: rtl/dma_chan_seq.sv
module dma_chan_seq #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] cfg_src,
  input  logic [AW-1:0] cfg_dst,
  input  logic [CW-1:0] cfg_cnt,
  input  logic          cfg_single,
  input  logic          cfg_indirect,
  input  logic          cfg_burst,
  input  logic          cfg_dack_is_src,
  input  logic          cfg_src_inc,
  input  logic          cfg_dst_inc,
  input  logic [2:0]    cfg_src_type,
  input  logic [2:0]    cfg_dst_type,
  input  logic          dreq,
  input  logic          bus_gnt,
  input  logic [DW-1:0] bus_rdata,
  output logic          bus_req,
  output logic [AW-1:0] bus_addr,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic          bus_dack,
  output logic [DW-1:0] bus_wdata,
  output logic          done,
  output logic          err
);
  localparam logic [AW-1:0] STEP = AW'(DW / 8);
  localparam logic [2:0] T_ACK = 3'd0, T_XMEM = 3'd1, T_XIO = 3'd2, T_LAST = 3'd4;

  typedef enum logic [2:0] {S_IDLE, S_ARM, S_REQ, S_SGL, S_PTR, S_RD, S_WR} st_t;

  st_t           st;
  logic [AW-1:0] src, dst, opa;
  logic [DW-1:0] dat;
  logic [CW-1:0] cnt;
  logic          m_single, m_ind, m_burst, m_dsrc, m_sinc, m_dinc;

  logic [2:0] ack_t, far_t;
  logic       legal, in_bus, go, unit_end;
  st_t        first_ph;

  assign ack_t = cfg_dack_is_src ? cfg_src_type : cfg_dst_type;
  assign far_t = cfg_dack_is_src ? cfg_dst_type : cfg_src_type;
  assign legal = (cfg_cnt != '0) && (cfg_src_type <= T_LAST) && (cfg_dst_type <= T_LAST) &&
                 (cfg_single ? (!cfg_indirect && ack_t == T_ACK && (far_t == T_XMEM || far_t == T_XIO))
                             : (cfg_src_type != T_ACK && cfg_dst_type != T_ACK));

  assign in_bus   = (st == S_SGL) || (st == S_PTR) || (st == S_RD) || (st == S_WR);
  assign go       = in_bus && bus_gnt;
  assign unit_end = go && (st == S_SGL || st == S_WR);
  assign first_ph = m_single ? S_SGL : (m_ind ? S_PTR : S_RD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      src <= '0; dst <= '0; opa <= '0; dat <= '0; cnt <= '0;
      m_single <= 1'b0; m_ind <= 1'b0; m_burst <= 1'b0;
      m_dsrc <= 1'b0; m_sinc <= 1'b0; m_dinc <= 1'b0;
      done <= 1'b0; err <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          done <= 1'b0;
          err  <= !legal;
          if (legal) begin
            src <= cfg_src; dst <= cfg_dst; cnt <= cfg_cnt;
            m_single <= cfg_single; m_ind <= cfg_indirect; m_burst <= cfg_burst;
            m_dsrc <= cfg_dack_is_src; m_sinc <= cfg_src_inc; m_dinc <= cfg_dst_inc;
            st <= S_ARM;
          end
        end
        S_ARM: if (dreq) st <= S_REQ;
        S_REQ: if (bus_gnt) st <= first_ph;
        S_PTR: if (bus_gnt) begin opa <= AW'(bus_rdata); st <= S_RD; end
        S_RD:  if (bus_gnt) begin dat <= bus_rdata; st <= S_WR; end
        default: ;
      endcase
      if (unit_end) begin
        cnt <= cnt - 1'b1;
        if (m_sinc) src <= src + STEP;
        if (m_dinc) dst <= dst + STEP;
        if (cnt == CW'(1)) begin
          done <= 1'b1;
          st   <= S_IDLE;
        end else begin
          st <= m_burst ? first_ph : S_ARM;
        end
      end
    end
  end

  assign bus_req  = (st == S_REQ) || in_bus;
  assign bus_dack = go && (st == S_SGL);
  assign bus_rd   = go && ((st == S_PTR) || (st == S_RD) || (st == S_SGL && !m_dsrc));
  assign bus_wr   = go && ((st == S_WR) || (st == S_SGL && m_dsrc));
  assign bus_wdata = (st == S_WR) ? dat : '0;

  always_comb begin
    case (st)
      S_SGL:   bus_addr = m_dsrc ? dst : src;
      S_PTR:   bus_addr = src;
      S_RD:    bus_addr = m_ind ? opa : src;
      S_WR:    bus_addr = dst;
      default: bus_addr = '0;
    endcase
  end

  a_r1_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !bus_req);
  a_r2_dack_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    bus_dack |-> (m_single && $countones({bus_rd, bus_wr}) == 1));
  a_r3_dual_no_dack: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !m_single) |-> !bus_dack);
  a_r6_steal_release: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_end && !m_burst) |=> !bus_req);
  a_r7_burst_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_end && m_burst && cnt != CW'(1)) |=> bus_req);
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(bus_req || bus_rd || bus_wr));
  a_r8_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    unit_end |=> (done || cnt == $past(cnt) - 1'b1));
  a_r9_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE) |=> $stable({m_single, m_ind, m_burst, m_dsrc}));
  a_r11_strobe_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || bus_wr || bus_dack) |-> (bus_req && bus_gnt));
endmodule

// File: tb/tb_dma_chan_seq.sv
module tb_dma_chan_seq;
  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [31:0] cfg_src = '0, cfg_dst = '0;
  logic [15:0] cfg_cnt = '0;
  logic        cfg_single = 0, cfg_indirect = 0, cfg_burst = 0, cfg_dack_is_src = 0;
  logic        cfg_src_inc = 0, cfg_dst_inc = 0;
  logic [2:0]  cfg_src_type = 3'd1, cfg_dst_type = 3'd1;
  logic        dreq = 1'b0, bus_gnt = 1'b0;
  logic [31:0] bus_rdata, bus_addr, bus_wdata;
  logic        bus_req, bus_rd, bus_wr, bus_dack, done, err;

  dma_chan_seq dut (.*);

  always #5 clk = ~clk;

  logic [31:0] mem [64];
  assign bus_rdata = mem[bus_addr[7:2]];

  int checks = 0, fails = 0;
  logic [66:0] lg [64];
  logic [66:0] ex [64];
  int lg_n = 0, ex_n = 0, rises = 0;
  logic prev_req = 1'b0, rnd_gnt = 1'b1;

  task automatic chk(input logic ok, input string req, input logic [66:0] act, input logic [66:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic legal_cfg();
    logic [2:0] a, f;
    a = cfg_dack_is_src ? cfg_src_type : cfg_dst_type;
    f = cfg_dack_is_src ? cfg_dst_type : cfg_src_type;
    if (cfg_cnt == 0 || cfg_src_type > 4 || cfg_dst_type > 4) return 1'b0;
    if (cfg_single) return !cfg_indirect && a == 0 && (f == 1 || f == 2);
    return cfg_src_type != 0 && cfg_dst_type != 0;
  endfunction

  task automatic build_exp();
    logic [31:0] s, d, p;
    s = cfg_src; d = cfg_dst; ex_n = 0;
    for (int u = 0; u < int'(cfg_cnt); u++) begin
      if (cfg_single) begin
        if (cfg_dack_is_src) ex[ex_n++] = {3'b011, d, 32'h0};
        else                 ex[ex_n++] = {3'b101, s, 32'h0};
      end else if (cfg_indirect) begin
        p = mem[s[7:2]];
        ex[ex_n++] = {3'b100, s, 32'h0};
        ex[ex_n++] = {3'b100, p, 32'h0};
        ex[ex_n++] = {3'b010, d, mem[p[7:2]]};
      end else begin
        ex[ex_n++] = {3'b100, s, 32'h0};
        ex[ex_n++] = {3'b010, d, mem[s[7:2]]};
      end
      if (cfg_src_inc) s += 4;
      if (cfg_dst_inc) d += 4;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk); #2;
      bus_gnt = bus_req && (!rnd_gnt || ($urandom % 4 != 0));
      #1;
      if (bus_req && !prev_req) rises++;
      prev_req = bus_req;
      if ((bus_rd || bus_wr) && lg_n < 64)
        lg[lg_n++] = {bus_rd, bus_wr, bus_dack, bus_addr, bus_wr ? bus_wdata : 32'h0};
    end
  end

  task automatic pulse_start();
    @(posedge clk); #2; start = 1'b1;
    @(posedge clk); #2; start = 1'b0;
  endtask

  task automatic wait_end();
    for (int i = 0; i < 3000; i++) begin
      @(posedge clk); #4;
      if (done || err) return;
    end
    chk(1'b0, "R8 timeout waiting for done", 0, 1);
  endtask

  task automatic compare_trace(input string req);
    chk(lg_n == ex_n, {req, " cycle count"}, 67'(lg_n), 67'(ex_n));
    for (int i = 0; i < ex_n && i < lg_n; i++)
      chk(lg[i] == ex[i], {req, " trace entry"}, lg[i], ex[i]);
  endtask

  task automatic check_finish(input string req);
    chk(done === 1'b1 && err === 1'b0 && bus_req === 1'b0, "R8 done/released", {done, err, bus_req}, 3'b100);
    compare_trace(req);
    chk(rises == (cfg_burst ? 1 : int'(cfg_cnt)), cfg_burst ? "R7 request rises" : "R6 request rises",
        67'(rises), 67'(cfg_burst ? 1 : int'(cfg_cnt)));
  endtask

  task automatic run_xfer(input string req);
    lg_n = 0; rises = 0;
    if (legal_cfg()) begin
      build_exp();
      pulse_start();
      wait_end();
      check_finish(req);
    end else begin
      pulse_start();
      repeat (6) @(posedge clk);
      #4;
      chk(err === 1'b1 && done === 1'b0 && bus_req === 1'b0 && lg_n == 0, "R1 illegal rejected",
          {err, done, bus_req, 32'(lg_n)}, 35'h400000000);
    end
  endtask

  task automatic set_cfg(input logic sg, input logic ind, input logic bu, input logic ds,
                         input logic si, input logic di, input logic [2:0] st, input logic [2:0] dt,
                         input logic [31:0] s, input logic [31:0] d, input logic [15:0] c);
    @(posedge clk); #2;
    cfg_single = sg; cfg_indirect = ind; cfg_burst = bu; cfg_dack_is_src = ds;
    cfg_src_inc = si; cfg_dst_inc = di; cfg_src_type = st; cfg_dst_type = dt;
    cfg_src = s; cfg_dst = d; cfg_cnt = c;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 64; i++)
      mem[i] = (i < 16) ? 32'h80 + 32'(4 * i) : (i < 32) ? 32'h5A000000 + 32'(i) :
               (i < 48) ? 32'hC0DE0000 + 32'(i) : 32'h0;
    repeat (3) @(posedge clk);
    #4;
    chk({bus_req, bus_rd, bus_wr, bus_dack, done, err} == 6'b0, "R10 reset state",
        {bus_req, bus_rd, bus_wr, bus_dack, done, err}, 0);
    rst_n = 1'b1;
    dreq = 1'b1;

    set_cfg(0, 0, 0, 0, 1, 1, 3'd1, 3'd3, 32'h40, 32'hC0, 16'd3); run_xfer("R3 dual direct");
    set_cfg(0, 1, 1, 0, 1, 1, 3'd3, 3'd4, 32'h00, 32'hC0, 16'd4); run_xfer("R4 indirect");
    set_cfg(0, 1, 0, 0, 0, 1, 3'd2, 3'd1, 32'h08, 32'hC4, 16'd2); run_xfer("R5 fixed pointer");
    set_cfg(1, 0, 1, 1, 0, 1, 3'd0, 3'd1, 32'h40, 32'hC0, 16'd3); run_xfer("R2 single dack source");
    set_cfg(1, 0, 0, 0, 1, 0, 3'd2, 3'd0, 32'h44, 32'hC0, 16'd2); run_xfer("R2 single dack dest");
    set_cfg(1, 0, 0, 0, 1, 0, 3'd3, 3'd0, 32'h44, 32'hC0, 16'd2); run_xfer("R1 single on-chip");
    set_cfg(0, 0, 0, 0, 1, 0, 3'd0, 3'd1, 32'h44, 32'hC0, 16'd2); run_xfer("R1 dual with dack");
    set_cfg(0, 0, 0, 0, 1, 0, 3'd1, 3'd1, 32'h44, 32'hC0, 16'd0); run_xfer("R1 zero count");
    set_cfg(1, 1, 0, 1, 1, 0, 3'd0, 3'd1, 32'h44, 32'hC0, 16'd2); run_xfer("R1 single indirect");

    // R6: cycle-steal waits for dreq between units
    set_cfg(0, 0, 0, 0, 1, 1, 3'd1, 3'd1, 32'h48, 32'hC0, 16'd3);
    lg_n = 0; rises = 0; build_exp(); pulse_start();
    for (int i = 0; i < 500 && lg_n < 2; i++) begin @(posedge clk); #4; end
    dreq = 1'b0;
    repeat (10) @(posedge clk);
    #4;
    chk(lg_n == 2 && bus_req == 1'b0 && done == 1'b0, "R6 stalled without dreq",
        {32'(lg_n), bus_req, done}, {32'd2, 2'b00});
    dreq = 1'b1;
    wait_end(); check_finish("R6 resumed");

    // R7: burst ignores dreq after start
    set_cfg(0, 0, 1, 0, 1, 1, 3'd4, 3'd1, 32'h40, 32'hC0, 16'd4);
    lg_n = 0; rises = 0; build_exp(); pulse_start();
    for (int i = 0; i < 500 && lg_n < 1; i++) begin @(posedge clk); #4; end
    dreq = 1'b0;
    wait_end(); check_finish("R7 burst");
    dreq = 1'b1;

    // R9: start and config changes mid-transfer are ignored
    set_cfg(0, 0, 0, 0, 1, 1, 3'd1, 3'd1, 32'h40, 32'hC0, 16'd4);
    lg_n = 0; rises = 0; build_exp(); pulse_start();
    for (int i = 0; i < 500 && lg_n < 1; i++) begin @(posedge clk); #4; end
    cfg_src = 32'h0; cfg_cnt = 16'd1; cfg_single = 1'b1; cfg_burst = 1'b1;
    pulse_start();
    wait_end();
    chk(done === 1'b1 && err === 1'b0, "R9 done unchanged", {done, err}, 2'b10);
    compare_trace("R9 trace unchanged");
    chk(rises == 4, "R9 request rises", 67'(rises), 67'd4);

    // R11 with grant always present, then random mixture
    rnd_gnt = 1'b0;
    set_cfg(0, 1, 0, 0, 1, 1, 3'd1, 3'd3, 32'h04, 32'hC8, 16'd2); run_xfer("R11 full grant indirect");
    rnd_gnt = 1'b1;
    for (int n = 0; n < 40; n++) begin
      logic sg, ind, ds;
      logic [2:0] st, dt;
      logic [15:0] c;
      sg = ($urandom % 3 == 0); ds = $urandom % 2; ind = sg ? 1'b0 : 1'($urandom % 2);
      c = 16'(1 + $urandom % 8);
      if (sg) begin
        st = ds ? 3'd0 : 3'(1 + $urandom % 2);
        dt = ds ? 3'(1 + $urandom % 2) : 3'd0;
      end else begin
        st = 3'(1 + $urandom % 4); dt = 3'(1 + $urandom % 4);
      end
      case ($urandom % 8)
        0: st = 3'($urandom % 8);
        1: c = 16'd0;
        2: ind = 1'b1;
        default: ;
      endcase
      set_cfg(sg, ind, 1'($urandom % 2), ds, 1'($urandom % 2), 1'($urandom % 2), st, dt,
              (ind ? 32'h00 : 32'h40) + 32'(4 * ($urandom % 8)), 32'hC0 + 32'(4 * ($urandom % 8)), c);
      run_xfer("R11 random mix");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule